// File: doc/BRIEF.md
# Logical-Time Access Replay Checker

This block sits at a home memory node and checks, end to end, that the loads reaching the node's blocks return legal values. Processors send one notification per memory access. Each notification carries the block address, a store or load marker, the data value and a logical timestamp. Timestamps follow causality: when one access causes another, the cause carries the smaller timestamp.

Notifications arrive in whatever order the network delivers them. The block files each one into a sorted holding queue, so no ordering is assumed at the input. It then replays the queue head first, which is the entry with the smallest timestamp. A replayed store writes a private shadow copy of the addressed block. A replayed load compares its data with that shadow copy. A difference means the memory system returned a stale or corrupted value. The block then reports the address and the timestamp of the offending load and raises a recovery request.

Before any access touches a location, software-independent setup logic writes its starting value into the shadow copy through a preload port. The queue holds 16 entries. Replay happens when the queue is full or when the drain input is high. While the queue is full, the input refuses new notifications.

Top module: `ltr_checker`

## Requirements
- R1: `inf_ready` is low exactly while the queue holds 16 entries. A notification is accepted on a rising edge where `inf_valid` and `inf_ready` are both high.
- R2: While the queue is full, the head entry is replayed on the next rising edge whether or not `drain` is high, so `inf_ready` returns high one cycle after the queue fills.
- R3: While the queue is not full and `drain` is low, nothing is replayed. While `drain` is high, one entry is replayed per cycle until the queue is empty.
- R4: Entries are replayed in non-decreasing timestamp order. Timestamps are unsigned and wrap-free. Among entries with equal timestamps, the one accepted first is replayed first.
- R5: A replayed store (`inf_store` = 1) sets the shadow value of its address to its data. A load replayed after it in logical order compares against that data.
- R6: `pre_valid` writes `pre_data` into the shadow location `pre_addr` on the rising edge. A load to a location with no earlier replayed store compares against the preloaded value.
- R7: A replayed load (`inf_store` = 0) whose data differs from the shadow value raises `err_valid` for exactly one cycle, on the edge after its replay. In that cycle `err_addr` and `err_ts` hold the load's address and timestamp.
- R8: `recover_req` goes high together with the first `err_valid` and stays high until reset.
- R9: A load whose data matches the shadow value raises no error. A load never changes the shadow copy, so a mismatching load does not alter what later loads compare against.
- R10: After synchronous reset the queue is empty, `inf_ready` is high, `err_valid` and `recover_req` are low, and every shadow location reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inf_valid | input | 1 | Access notification present |
| inf_ready | output | 1 | Queue can accept a notification |
| inf_addr | input | 4 | Block address of the access |
| inf_store | input | 1 | 1 = store, 0 = load |
| inf_data | input | 8 | Value stored or value the load returned |
| inf_ts | input | 8 | Logical timestamp of the access |
| drain | input | 1 | Replay one entry per cycle while high |
| pre_valid | input | 1 | Write an initial shadow value |
| pre_addr | input | 4 | Address of the initial value |
| pre_data | input | 8 | Initial shadow value |
| err_valid | output | 1 | One-cycle pulse for a mismatching load |
| err_addr | output | 4 | Address of the mismatching load |
| err_ts | output | 8 | Timestamp of the mismatching load |
| recover_req | output | 1 | Sticky request for system recovery |

## Verification
The assertions take three things for granted about the inputs:
- Timestamps never wrap while entries are queued.
- A preload never targets the address of a store being replayed in the same cycle.
- `inf_valid` is raised only when `inf_ready` was seen high.

The stimulus writes every preload value before any notification is sent, keeps all timestamps below 64, and offers a notification only after sampling `inf_ready` high between clock edges. Expected error counts come from a bench-side rule that decides whether the store or the load of each pair comes first in logical order, ties included.

// File: rtl/ltr_pkg.sv
package ltr_pkg;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned TS_W    = 8;
    localparam int unsigned Q_DEPTH = 16;
    localparam int unsigned N_LOC   = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TS_W-1:0]   ts_t;

    typedef struct packed {
        addr_t addr;
        logic  is_store;
        data_t data;
        ts_t   ts;
    } inform_t;

    typedef struct packed {
        logic  hit;
        addr_t addr;
        ts_t   ts;
    } verdict_t;

    // an already-queued entry stays ahead of a newcomer with the same stamp
    function automatic logic stays_ahead(input ts_t queued, input ts_t incoming);
        return queued <= incoming;
    endfunction

    function automatic logic load_mismatch(input inform_t ent, input data_t shadow);
        return !ent.is_store && (ent.data != shadow);
    endfunction
endpackage

// File: rtl/ltr_sort_queue.sv
module ltr_sort_queue
    import ltr_pkg::*;
#(
    parameter int unsigned DEPTH = Q_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  inform_t push_ent,
    input  logic    pop,
    output inform_t head,
    output logic    head_vld,
    output logic    full
);
    inform_t            ent_q  [DEPTH];
    logic [DEPTH-1:0]   vld_q;
    inform_t            sh     [DEPTH];
    logic [DEPTH-1:0]   sh_vld;
    logic [DEPTH-1:0]   le;
    inform_t            nxt    [DEPTH];
    logic [DEPTH-1:0]   nxt_vld;

    assign head     = ent_q[0];
    assign head_vld = vld_q[0];
    assign full     = vld_q[DEPTH-1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // view of the queue after an optional pop of the head
        if (i < DEPTH-1) begin : g_shift
            always_comb begin
                sh[i]     = pop ? ent_q[i+1] : ent_q[i];
                sh_vld[i] = pop ? vld_q[i+1] : vld_q[i];
            end
        end else begin : g_last
            always_comb begin
                sh[i]     = pop ? '0 : ent_q[i];
                sh_vld[i] = pop ? 1'b0 : vld_q[i];
            end
        end

        assign le[i] = sh_vld[i] && stays_ahead(sh[i].ts, push_ent.ts);

        // stable insertion: keep, take the newcomer, or shift down by one
        if (i == 0) begin : g_first
            always_comb begin
                if (!push || le[i]) begin
                    nxt[i]     = sh[i];
                    nxt_vld[i] = sh_vld[i];
                end else begin
                    nxt[i]     = push_ent;
                    nxt_vld[i] = 1'b1;
                end
            end
        end else begin : g_rest
            always_comb begin
                if (!push || le[i]) begin
                    nxt[i]     = sh[i];
                    nxt_vld[i] = sh_vld[i];
                end else if (le[i-1]) begin
                    nxt[i]     = push_ent;
                    nxt_vld[i] = 1'b1;
                end else begin
                    nxt[i]     = sh[i-1];
                    nxt_vld[i] = sh_vld[i-1];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
                vld_q[i] <= 1'b0;
            end else begin
                ent_q[i] <= nxt[i];
                vld_q[i] <= nxt_vld[i];
            end
        end

        if (i > 0) begin : g_chk
            // R4: stored entries stay sorted by timestamp
            p_sorted_r4: assert property (@(posedge clk) disable iff (rst)
                vld_q[i] |-> (ent_q[i-1].ts <= ent_q[i].ts));
            // R1: occupied slots form a contiguous run from the head
            p_contig_r1: assert property (@(posedge clk) disable iff (rst)
                vld_q[i] |-> vld_q[i-1]);
        end
    end

    // R1: a full queue never takes a new entry
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    p_no_empty_pop_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_vld);
endmodule

// File: rtl/ltr_shadow_mem.sv
module ltr_shadow_mem
    import ltr_pkg::*;
#(
    parameter int unsigned LOCS = N_LOC
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  st_we,
    input  addr_t st_addr,
    input  data_t st_data,
    input  logic  pl_we,
    input  addr_t pl_addr,
    input  data_t pl_data,
    input  addr_t rd_addr,
    output data_t rd_data
);
    data_t mem_q [LOCS];

    assign rd_data = mem_q[rd_addr];

    for (genvar j = 0; j < LOCS; j++) begin : g_loc
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[j] <= '0;
            end else if (st_we && st_addr == addr_t'(j)) begin
                mem_q[j] <= st_data;
            end else if (pl_we && pl_addr == addr_t'(j)) begin
                mem_q[j] <= pl_data;
            end
        end
    end

    // R6: preload and replayed store never aim at the same location at once
    p_preload_no_clash_r6: assert property (@(posedge clk) disable iff (rst)
        (pl_we && st_we) |-> (pl_addr != st_addr));

    // R5: a replayed store is visible at its address on the next cycle
    p_store_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (st_we && rd_addr == st_addr) |=> (rd_addr != $past(st_addr)) || (rd_data == $past(st_data)) || $past(pl_we));
endmodule

// File: rtl/ltr_replay_verifier.sv
module ltr_replay_verifier
    import ltr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire,
    input  inform_t ent,
    input  data_t   shadow,
    output logic    err_valid,
    output addr_t   err_addr,
    output ts_t     err_ts,
    output logic    recover_req
);
    verdict_t v_d, v_q;
    logic     rec_q;

    always_comb begin
        v_d.hit  = fire && load_mismatch(ent, shadow);
        v_d.addr = ent.addr;
        v_d.ts   = ent.ts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= '0;
            rec_q <= 1'b0;
        end else begin
            v_q.hit <= v_d.hit;
            if (v_d.hit) begin
                v_q.addr <= v_d.addr;
                v_q.ts   <= v_d.ts;
            end
            rec_q <= rec_q | v_d.hit;
        end
    end

    assign err_valid   = v_q.hit;
    assign err_addr    = v_q.addr;
    assign err_ts      = v_q.ts;
    assign recover_req = rec_q;

    // R8: recovery request never drops without reset
    p_recover_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        recover_req |=> recover_req);

    // R8: every reported error is accompanied by the recovery request
    p_err_recover_r8: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> recover_req);

    // R9: a replayed store never produces an error
    p_store_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && ent.is_store) |=> !err_valid);
endmodule

// File: rtl/ltr_checker.sv
module ltr_checker
    import ltr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inf_valid,
    output logic              inf_ready,
    input  logic [ADDR_W-1:0] inf_addr,
    input  logic              inf_store,
    input  logic [DATA_W-1:0] inf_data,
    input  logic [TS_W-1:0]   inf_ts,
    input  logic              drain,
    input  logic              pre_valid,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [TS_W-1:0]   err_ts,
    output logic              recover_req
);
    inform_t in_ent, head;
    logic    head_vld, q_full, push, pop;
    data_t   shadow_rd;

    always_comb begin
        in_ent.addr     = inf_addr;
        in_ent.is_store = inf_store;
        in_ent.data     = inf_data;
        in_ent.ts       = inf_ts;
    end

    assign inf_ready = !q_full;
    assign push      = inf_valid && inf_ready;
    assign pop       = head_vld && (q_full || drain);

    ltr_sort_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (in_ent),
        .pop      (pop),
        .head     (head),
        .head_vld (head_vld),
        .full     (q_full)
    );

    ltr_shadow_mem #(.LOCS(N_LOC)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .st_we   (pop && head.is_store),
        .st_addr (head.addr),
        .st_data (head.data),
        .pl_we   (pre_valid),
        .pl_addr (pre_addr),
        .pl_data (pre_data),
        .rd_addr (head.addr),
        .rd_data (shadow_rd)
    );

    ltr_replay_verifier u_verify (
        .clk         (clk),
        .rst         (rst),
        .fire        (pop),
        .ent         (head),
        .shadow      (shadow_rd),
        .err_valid   (err_valid),
        .err_addr    (err_addr),
        .err_ts      (err_ts),
        .recover_req (recover_req)
    );

    // R2: a full queue always gives up its head on the next edge
    p_full_replay_r2: assert property (@(posedge clk) disable iff (rst)
        q_full |=> !q_full || $past(push));

    // R7: an error pulse follows a replay on the previous edge
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(pop));

    // R7: error pulses last one cycle unless two replays failed back to back
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !pop) |=> !err_valid);

    // R3: with room left and no drain the queue only grows or holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!q_full && !drain && head_vld) |=> head_vld);
endmodule

// File: tb/ltr_checker_tb_top.sv
module ltr_checker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       inf_valid, inf_ready, inf_store, drain, pre_valid;
    logic [3:0] inf_addr, pre_addr, err_addr;
    logic [7:0] inf_data, inf_ts, pre_data, err_ts;
    logic       err_valid, recover_req;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    logic [3:0] last_addr = '0;
    logic [7:0] last_ts = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ltr_checker dut_i (
        .clk(clk), .rst(rst),
        .inf_valid(inf_valid), .inf_ready(inf_ready),
        .inf_addr(inf_addr), .inf_store(inf_store),
        .inf_data(inf_data), .inf_ts(inf_ts),
        .drain(drain),
        .pre_valid(pre_valid), .pre_addr(pre_addr), .pre_data(pre_data),
        .err_valid(err_valid), .err_addr(err_addr), .err_ts(err_ts),
        .recover_req(recover_req)
    );

    always @(negedge clk) begin
        if (!rst && err_valid) begin
            err_seen++;
            last_addr = err_addr;
            last_ts   = err_ts;
        end
    end

    // store/load pair on one address; lf = load offered first
    typedef struct packed {
        logic [3:0] a;
        logic [7:0] sd;
        logic [7:0] tss;
        logic [7:0] ld;
        logic [7:0] tsl;
        logic       lf;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{4'd1,  8'hAA, 8'd5,  8'hAA, 8'd6,  1'b1},
        '{4'd2,  8'hBB, 8'd9,  8'hBB, 8'd4,  1'b0},
        '{4'd4,  8'h11, 8'd7,  8'h11, 8'd7,  1'b0},
        '{4'd6,  8'h22, 8'd7,  8'h22, 8'd7,  1'b1},
        '{4'd8,  8'h33, 8'd3,  8'h34, 8'd8,  1'b1},
        '{4'd10, 8'h44, 8'd20, 8'd173, 8'd2, 1'b1}
    };

    function automatic logic [7:0] pre_val(input logic [3:0] a);
        return 8'(a * 17 + 3);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] a, input logic st, input logic [7:0] d, input logic [7:0] ts);
        @(negedge clk);
        while (!inf_ready) @(negedge clk);
        inf_valid = 1'b1; inf_addr = a; inf_store = st; inf_data = d; inf_ts = ts;
        @(negedge clk);
        inf_valid = 1'b0;
    endtask

    task automatic run_drain(input int n);
        @(negedge clk);
        drain = 1'b1;
        repeat (n) @(negedge clk);
        drain = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic preload_all();
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            pre_valid = 1'b1; pre_addr = 4'(k); pre_data = pre_val(4'(k));
        end
        @(negedge clk);
        pre_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        inf_valid = 0; inf_addr = 0; inf_store = 0; inf_data = 0; inf_ts = 0;
        drain = 0; pre_valid = 0; pre_addr = 0; pre_data = 0;
        do_reset();

        // R10 reset state
        check(inf_ready == 1'b1, "R10 ready", int'(inf_ready), 1);
        check(err_valid == 1'b0, "R10 err", int'(err_valid), 0);
        check(recover_req == 1'b0, "R10 recover", int'(recover_req), 0);
        // R10 shadow reads zero: load of 0 passes
        send(4'd2, 1'b0, 8'h00, 8'd1);
        run_drain(4);
        check(err_seen == 0, "R10 shadow zero", err_seen, 0);

        preload_all();

        // R4 R5 R6 table of pairs with bench-computed verdicts
        for (int r = 0; r < NROWS; r++) begin
            logic sfirst;
            logic [7:0] eff;
            int exp_err;
            sfirst  = (ROWS[r].tss < ROWS[r].tsl) || (ROWS[r].tss == ROWS[r].tsl && !ROWS[r].lf);
            eff     = sfirst ? ROWS[r].sd : pre_val(ROWS[r].a);
            exp_err = (eff != ROWS[r].ld) ? 1 : 0;
            base    = err_seen;
            if (ROWS[r].lf) begin
                send(ROWS[r].a, 1'b0, ROWS[r].ld, ROWS[r].tsl);
                send(ROWS[r].a, 1'b1, ROWS[r].sd, ROWS[r].tss);
            end else begin
                send(ROWS[r].a, 1'b1, ROWS[r].sd, ROWS[r].tss);
                send(ROWS[r].a, 1'b0, ROWS[r].ld, ROWS[r].tsl);
            end
            run_drain(5);
            check(err_seen - base == exp_err, "R4 R5 R6 pair verdict", err_seen - base, exp_err);
            if (exp_err == 1) begin
                check(last_addr == ROWS[r].a, "R7 err_addr", int'(last_addr), int'(ROWS[r].a));
                check(last_ts == ROWS[r].tsl, "R7 err_ts", int'(last_ts), int'(ROWS[r].tsl));
            end
        end
        check(recover_req == 1'b1, "R8 recover after errors", int'(recover_req), 1);

        // R3 no replay without full or drain
        base = err_seen;
        send(4'd7, 1'b0, 8'h00, 8'd30);
        repeat (8) @(negedge clk);
        #1;
        check(err_seen == base, "R3 held without drain", err_seen - base, 0);
        run_drain(4);
        check(err_seen == base + 1, "R3 drain replays", err_seen - base, 1);
        check(last_addr == 4'd7, "R7 addr on drain", int'(last_addr), 7);

        // R9 mismatching load leaves shadow intact
        base = err_seen;
        send(4'd9, 1'b0, 8'h01, 8'd1);
        send(4'd9, 1'b0, pre_val(4'd9), 8'd2);
        run_drain(5);
        check(err_seen == base + 1, "R9 only one error", err_seen - base, 1);

        // R1 R2 R4 fill the queue; smallest stamp arrives last
        base = err_seen;
        for (int k = 0; k < 15; k++)
            send(4'd5, 1'b0, pre_val(4'd5), 8'(10 + k));
        check(inf_ready == 1'b1, "R1 ready at 15", int'(inf_ready), 1);
        send(4'd3, 1'b0, 8'h00, 8'd1);
        // now at negedge after the 16th acceptance edge
        #1;
        check(inf_ready == 1'b0, "R1 ready low when full", int'(inf_ready), 0);
        check(err_seen == base, "R2 nothing before replay", err_seen - base, 0);
        @(negedge clk);
        #1;
        check(inf_ready == 1'b1, "R2 ready after replay", int'(inf_ready), 1);
        check(err_seen == base + 1, "R2 full replays head", err_seen - base, 1);
        check(last_addr == 4'd3, "R4 smallest stamp first", int'(last_addr), 3);
        run_drain(20);
        check(err_seen == base + 1, "R2 remaining match", err_seen - base, 1);
        check(recover_req == 1'b1, "R8 sticky", int'(recover_req), 1);

        // R10 reset clears recovery
        do_reset();
        check(recover_req == 1'b0, "R10 recover cleared", int'(recover_req), 0);
        check(inf_ready == 1'b1, "R10 ready again", int'(inf_ready), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule